// File: doc/BRIEF.md
# Reference Health Monitor with Frozen-Frequency Holdover

This block sits in front of a digital PLL and decides whether the loop may follow its reference. It counts edges of an already-synchronised reference strobe over a fixed gate window of `GATE_CYCLES` system clocks. At the end of each window it compares the count with an inclusive band given by two limits. A window whose count falls outside the band puts the block into holdover. That covers both a reference that has disappeared and one that has jumped in frequency. No external command is needed. Holdover ends only after two in-range windows in a row.

While the loop tracks normally, the block keeps a two-slot history of the loop's frequency word. Every `SNAP_WINDOWS` in-range windows, the newer slot moves to the older slot and the live word is captured into the newer slot. The holdover word output always shows the older slot. At the moment holdover begins, that slot is between one and two snapshot periods old. With a 30 ms period this gives a word from 30 to 60 ms before the fault, so the faulty stretch itself is never used. Captures stop in holdover. On every return to normal, the history is marked empty and filling starts again.

Top module: `ref_guard_holdover`

## Requirements
- R1: While reset is asserted and right after it, `in_holdover` is 1, `hist_valid` is 0 and `hold_word` is 0.
- R2: Each gate window spans `GATE_CYCLES` clocks from reset release; a `ref_tick` sampled on any clock of the window counts, including the last one. The count saturates at 2^`CNT_W`-1. The window is in range if and only if `band_lo` <= count <= `band_hi`.
- R3: A window with no reference edges is out of range and sets `in_holdover` to 1 on the clock after the window's last clock.
- R4: A window whose count exceeds `band_hi` sets holdover even though edges are present.
- R5: `in_holdover` returns to 0 only after two consecutive in-range windows; any out-of-range window in between restarts that count.
- R6: `in_holdover` changes only on the clock right after a window's last clock.
- R7: In normal mode, at the end of every `SNAP_WINDOWS`-th in-range window, the newer slot moves to the older slot and `live_word` (sampled on that window's last clock) enters the newer slot. `hold_word` shows the older slot.
- R8: No capture takes place while in holdover or on the window that enters it, so `hold_word` is constant throughout holdover.
- R9: `hist_valid` is 1 once two captures have happened since the last reset or return to normal. It clears on reset and on each return to normal. The slot contents themselves are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times the gate windows |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-clock strobe per reference edge, already synchronised |
| live_word | input | WORD_W | Current frequency control word of the loop |
| band_lo | input | CNT_W | Lowest in-range edge count (inclusive) |
| band_hi | input | CNT_W | Highest in-range edge count (inclusive) |
| in_holdover | output | 1 | 1 = holdover, 0 = tracking the reference |
| hold_word | output | WORD_W | Aged frequency word to use in holdover |
| hist_valid | output | 1 | Both history slots filled since the last restart |

## Verification
The checker watches these on every cycle: the mode flips only right after a window boundary, an out-of-range window in normal mode forces holdover, a return to normal follows two good windows, the holdover word stays frozen, and the valid flag is clear on each return. Other behaviour needs the bench's scenarios and its cycle-by-cycle model. That covers which word is captured and when, the count saturating at full scale, the inclusive band edges, and an out-of-range window breaking a recovery streak.

// File: rtl/rgh_pkg.sv
package rgh_pkg;

   typedef enum logic [1:0] {
      HIST_EMPTY = 2'd0,
      HIST_ONE   = 2'd1,
      HIST_FULL  = 2'd2
   } hist_fill_e;

   typedef enum logic {
      MODE_TRACK = 1'b0,
      MODE_HOLD  = 1'b1
   } loop_mode_e;

endpackage

// File: rtl/rgh_gate_timer.sv
module rgh_gate_timer #(
   parameter int GATE_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic gate_tick
);
   localparam int  TW   = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
   localparam bit  POW2 = ((GATE_CYCLES & (GATE_CYCLES - 1)) == 0);

   logic [TW-1:0] cnt_q;

   generate
      if (POW2) begin : g_wrap
         // window length is a power of two: let the counter roll over
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + TW'(1);
         end
         assign gate_tick = &cnt_q;
      end else begin : g_cmp
         localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);
         assign gate_tick = (cnt_q == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt_q <= '0;
            else if (gate_tick) cnt_q <= '0;
            else                cnt_q <= cnt_q + TW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/rgh_edge_meter.sv
module rgh_edge_meter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             gate_tick,
   input  logic [CNT_W-1:0] band_lo,
   input  logic [CNT_W-1:0] band_hi,
   output logic             win_ok
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] acc_q;
   logic [CNT_W-1:0] meas;

   // saturating count including the edge seen on the current clock
   always_comb begin
      if (acc_q == CMAX) meas = acc_q;
      else               meas = acc_q + {{(CNT_W-1){1'b0}}, ref_tick};
   end

   assign win_ok = (meas >= band_lo) && (meas <= band_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         acc_q <= '0;
      else if (gate_tick) acc_q <= '0;
      else                acc_q <= meas;
   end
endmodule

// File: rtl/rgh_mode_ctrl.sv
module rgh_mode_ctrl
   import rgh_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic gate_tick,
   input  logic win_ok,
   output logic hold_q,
   output logic resume,
   output logic capture_en
);
   loop_mode_e mode_q;
   logic       one_good_q;

   assign hold_q     = (mode_q == MODE_HOLD);
   assign resume     = gate_tick && win_ok && hold_q && one_good_q;
   assign capture_en = gate_tick && win_ok && !hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_HOLD;
         one_good_q <= 1'b0;
      end else if (gate_tick) begin
         if (!win_ok) begin
            mode_q     <= MODE_HOLD;
            one_good_q <= 1'b0;
         end else if (hold_q) begin
            if (one_good_q) begin
               mode_q     <= MODE_TRACK;
               one_good_q <= 1'b0;
            end else begin
               one_good_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rgh_snap_history.sv
module rgh_snap_history
   import rgh_pkg::*;
#(
   parameter int WORD_W       = 24,
   parameter int SNAP_WINDOWS = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_en,
   input  logic              resume,
   input  logic [WORD_W-1:0] live_word,
   output logic [WORD_W-1:0] hold_word,
   output logic              hist_valid
);
   localparam int PW = (SNAP_WINDOWS > 1) ? $clog2(SNAP_WINDOWS) : 1;
   localparam logic [PW-1:0] PLAST = PW'(SNAP_WINDOWS - 1);

   logic [PW-1:0]     per_q;
   logic [WORD_W-1:0] slot_new_q;
   logic [WORD_W-1:0] slot_old_q;
   hist_fill_e        fill_q;
   logic              shift_now;

   assign shift_now  = capture_en && (per_q == PLAST);
   assign hold_word  = slot_old_q;
   assign hist_valid = (fill_q == HIST_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= '0;
      end else if (resume || shift_now) begin
         per_q <= '0;
      end else if (capture_en) begin
         per_q <= per_q + PW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_new_q <= '0;
         slot_old_q <= '0;
      end else if (shift_now) begin
         slot_old_q <= slot_new_q;
         slot_new_q <= live_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q <= HIST_EMPTY;
      end else if (resume) begin
         fill_q <= HIST_EMPTY;
      end else if (shift_now) begin
         case (fill_q)
            HIST_EMPTY: fill_q <= HIST_ONE;
            default:    fill_q <= HIST_FULL;
         endcase
      end
   end
endmodule

// File: rtl/ref_guard_holdover.sv
module ref_guard_holdover #(
   parameter int GATE_CYCLES  = 1000,
   parameter int CNT_W        = 8,
   parameter int WORD_W       = 24,
   parameter int SNAP_WINDOWS = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic [WORD_W-1:0] live_word,
   input  logic [CNT_W-1:0]  band_lo,
   input  logic [CNT_W-1:0]  band_hi,
   output logic              in_holdover,
   output logic [WORD_W-1:0] hold_word,
   output logic              hist_valid
);
   generate
      if (GATE_CYCLES < 2) begin : g_bad_gate
         $error("GATE_CYCLES must be at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("WORD_W must be at least 1");
      end
      if (SNAP_WINDOWS < 1) begin : g_bad_snap
         $error("SNAP_WINDOWS must be at least 1");
      end
   endgenerate

   logic gate_tick;
   logic win_ok;
   logic resume;
   logic capture_en;

   rgh_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate_tick (gate_tick)
   );

   rgh_edge_meter #(.CNT_W(CNT_W)) i_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_tick  (ref_tick),
      .gate_tick (gate_tick),
      .band_lo   (band_lo),
      .band_hi   (band_hi),
      .win_ok    (win_ok)
   );

   rgh_mode_ctrl i_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_tick  (gate_tick),
      .win_ok     (win_ok),
      .hold_q     (in_holdover),
      .resume     (resume),
      .capture_en (capture_en)
   );

   rgh_snap_history #(.WORD_W(WORD_W), .SNAP_WINDOWS(SNAP_WINDOWS)) i_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_en (capture_en),
      .resume     (resume),
      .live_word  (live_word),
      .hold_word  (hold_word),
      .hist_valid (hist_valid)
   );
endmodule

// File: rtl/rgh_checker.sv
module rgh_checker #(
   parameter int WORD_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              gate_tick,
   input logic              win_ok,
   input logic              in_holdover,
   input logic [WORD_W-1:0] hold_word,
   input logic              hist_valid
);
   logic last_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         last_ok_q <= 1'b0;
      else if (gate_tick) last_ok_q <= win_ok;
   end

   assert_mode_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_holdover != $past(in_holdover)) |-> $past(gate_tick));

   // also covers R4: any out-of-range window in normal mode
   assert_enter_on_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_tick && !win_ok && !in_holdover) |=> in_holdover);

   assert_exit_two_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_holdover) |-> (last_ok_q && $past(last_ok_q)));

   assert_word_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_holdover && $past(in_holdover)) |-> $stable(hold_word));

   assert_valid_clear_on_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_holdover) |-> !hist_valid);
endmodule

bind ref_guard_holdover rgh_checker #(.WORD_W(WORD_W)) i_rgh_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .gate_tick   (gate_tick),
   .win_ok      (win_ok),
   .in_holdover (in_holdover),
   .hold_word   (hold_word),
   .hist_valid  (hist_valid)
);

// File: tb/test_ref_guard_holdover.sv
`timescale 1ns/1ps
module test_ref_guard_holdover;
   localparam int G    = 16;
   localparam int CW   = 4;
   localparam int WW   = 16;
   localparam int SNAP = 3;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_tick = 1'b0;
   logic [WW-1:0] live_word = '0;
   logic [CW-1:0] band_lo = CW'(3);
   logic [CW-1:0] band_hi = CW'(5);
   logic          in_holdover;
   logic [WW-1:0] hold_word;
   logic          hist_valid;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   bit cmp_on = 0;

   always #2.5 clk = ~clk;

   ref_guard_holdover #(.GATE_CYCLES(G), .CNT_W(CW), .WORD_W(WW), .SNAP_WINDOWS(SNAP)) i_ref_guard_holdover (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .live_word(live_word),
      .band_lo(band_lo), .band_hi(band_hi), .in_holdover(in_holdover),
      .hold_word(hold_word), .hist_valid(hist_valid));

   // behavioural reference model
   int m_t = 0, m_acc = 0, m_p = 0, m_fill = 0;
   bit m_hold = 1, m_run = 0;
   int m_old = 0, m_new = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_t = 0; m_acc = 0; m_p = 0; m_fill = 0;
         m_hold = 1; m_run = 0; m_old = 0; m_new = 0;
      end else begin
         int meas;
         bit edge_end, ok;
         edge_end = (m_t == G - 1);
         m_t = edge_end ? 0 : m_t + 1;
         meas = m_acc + (ref_tick ? 1 : 0);
         if (meas > CMAX) meas = CMAX;
         if (edge_end) begin
            ok = (meas >= int'(band_lo)) && (meas <= int'(band_hi));
            m_acc = 0;
            if (!ok) begin
               m_hold = 1; m_run = 0;
            end else if (m_hold) begin
               if (m_run) begin
                  m_hold = 0; m_run = 0; m_p = 0; m_fill = 0;
               end else m_run = 1;
            end else begin
               m_p = m_p + 1;
               if (m_p == SNAP) begin
                  m_old = m_new; m_new = int'(live_word); m_p = 0;
                  if (m_fill < 2) m_fill = m_fill + 1;
               end
            end
         end else m_acc = meas;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !finished) begin
         chk(in_holdover == m_hold, "R6 mode vs model", int'(in_holdover), int'(m_hold));
         chk(int'(hold_word) == m_old, "R7 word vs model", int'(hold_word), m_old);
         chk(hist_valid == (m_fill == 2), "R9 valid vs model", int'(hist_valid), int'(m_fill == 2));
      end
   end

   // one gate window: n edges placed on the last n clocks, word w throughout
   task automatic window(input int n, input int w);
      for (int i = 0; i < G; i++) begin
         ref_tick  = (i >= G - n);
         live_word = WW'(w);
         @(posedge clk);
         #1;
      end
      ref_tick = 1'b0;
   endtask

   function automatic int wd(input int k);
      return 'h1000 + k;
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(in_holdover == 1'b1, "R1 reset mode", int'(in_holdover), 1);
      chk(hist_valid == 1'b0, "R1 reset valid", int'(hist_valid), 0);
      chk(hold_word == '0, "R1 reset word", int'(hold_word), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1;
      window(4, wd(1));
      chk(in_holdover == 1'b1, "R5 one good window keeps holdover", int'(in_holdover), 1);
      window(4, wd(2));
      chk(in_holdover == 1'b0, "R5 two good windows resume", int'(in_holdover), 0);
      for (int k = 3; k <= 8; k++) begin
         window(4, wd(k));
         if (k == 5) begin
            chk(hold_word == WW'(0), "R7 older slot after first capture", int'(hold_word), 0);
            chk(hist_valid == 1'b0, "R9 one capture not valid", int'(hist_valid), 0);
         end
      end
      chk(hold_word == WW'(wd(5)), "R7 older slot after second capture", int'(hold_word), wd(5));
      chk(hist_valid == 1'b1, "R9 valid after two captures", int'(hist_valid), 1);
      window(4, wd(9));
      window(0, wd(10));
      chk(in_holdover == 1'b1, "R3 no edges forces holdover", int'(in_holdover), 1);
      chk(hold_word == WW'(wd(5)), "R7 aged word at entry", int'(hold_word), wd(5));
      window(4, wd(11));
      window(2, wd(12));
      chk(in_holdover == 1'b1, "R2 count lo-1 out of range", int'(in_holdover), 1);
      window(4, wd(13));
      chk(in_holdover == 1'b1, "R5 streak broken stays in holdover", int'(in_holdover), 1);
      chk(hold_word == WW'(wd(5)), "R8 word frozen in holdover", int'(hold_word), wd(5));
      window(3, wd(14));
      chk(in_holdover == 1'b0, "R2 count equal lo in range", int'(in_holdover), 0);
      chk(hist_valid == 1'b0, "R9 valid cleared on resume", int'(hist_valid), 0);
      chk(hold_word == WW'(wd(5)), "R9 slot kept on resume", int'(hold_word), wd(5));
      window(5, wd(15));
      chk(in_holdover == 1'b0, "R2 count equal hi in range", int'(in_holdover), 0);
      window(6, wd(16));
      chk(in_holdover == 1'b1, "R4 frequency step forces holdover", int'(in_holdover), 1);
      window(4, wd(17));
      window(4, wd(18));
      chk(in_holdover == 1'b0, "R5 resume after step", int'(in_holdover), 0);
      band_hi = CW'(CMAX);
      window(G, wd(19));
      chk(in_holdover == 1'b0, "R2 saturated count in range", int'(in_holdover), 0);
      band_hi = CW'(5);
      for (int k = 20; k <= 26; k++) window(4, wd(k));
      chk(in_holdover == 1'b0, "R6 steady tracking", int'(in_holdover), 0);
      window(1, wd(27));
      chk(in_holdover == 1'b1, "R3 sparse edges force holdover", int'(in_holdover), 1);
      chk(int'(hold_word) == m_old, "R8 entry word from history", int'(hold_word), m_old);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule